// File: doc/BRIEF.md
# Byte-Multiplexed IO Channel Controller

This controller shares a single byte-wide path to main memory among eight device trunks. Software opens an operation with a start command naming a device, a trunk, a start address, a byte count and a direction. The controller then serves the trunks whose devices ask for service and moves one byte on each service. The running address and the remaining count of a time-shared operation live in a per-device subchannel table. They are updated after every byte. When the count runs out, the operation's final state goes into a termination queue. The head of that queue is shown on a set of four 32-bit channel registers, and an interrupt stays raised until software acknowledges it.

A start command can also ask for burst mode. Burst mode hands the whole channel to one device. It is accepted only when no time-shared operation is open. While it runs, the controller keeps address and count in dedicated channel-level burst registers and leaves the subchannel table alone. It serves no trunk other than the burst trunk until the burst ends.

Top module: `mux_io_channel`

## Requirements
- R1: After reset, irq, memReq, trkAck, startOk and startErr are all low and regStatus reads zero.
- R2: Every start command gets exactly one response one cycle later: startOk when accepted, startErr when rejected. A start is rejected if its byte count is zero, if a burst is active, if its trunk already has an open operation (time-shared start), or if its device already has an open operation on another trunk.
- R3: A burst start is rejected with startErr while any time-shared operation is open, and accepted once none is.
- R4: The memory request keeps its address, direction and data stable from memReq until memReady. For device-to-memory transfers (memWrite=1), memWData is the byte the serviced trunk presents. The cycle after memReady, trkAck pulses one bit for the serviced trunk. For memory-to-device transfers, trkRdData then carries the memRdData returned with memReady.
- R5: An operation of count N gets exactly N services, at addresses start, start+1, ..., start+N-1.
- R6: Among trunks that are requesting and have an open operation, grants rotate round-robin. Each grant goes to the first such trunk above the previously granted trunk, in cyclic order.
- R7: A trunk with an open operation whose trkReq is low is never acknowledged.
- R8: While a burst is active, only the burst trunk is serviced, and a time-shared start is rejected.
- R9: On termination, irq rises. The head registers then show the following: regAddr holds the final address (start+count); regCount holds the original count; regCmd holds device in [7:0], trunk in [10:8], direction in bit 11 and the burst flag in bit 12; regStatus holds a pending flag in bit 0 and the queued count in [15:8]. irq stays high until irqAck.
- R10: Terminations queue up in completion order. Each irqAck pops one, exposing the next; irq falls only when the queue is empty.
- R11: A burst termination is reported through the same registers with bit 12 of regCmd set.
- R12: While the termination queue holds QDEPTH entries, no further byte is serviced until software acknowledges one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start command strobe |
| startDev | input | 8 | Device address of the command |
| startTrunk | input | 3 | Trunk the device sits on |
| startAddr | input | 24 | First memory address |
| startCount | input | 16 | Number of bytes |
| startWrite | input | 1 | 1 = device to memory, 0 = memory to device |
| startBurst | input | 1 | Request burst mode |
| startOk | output | 1 | Command accepted (one cycle after strobe) |
| startErr | output | 1 | Command rejected, program check |
| trkReq | input | 8 | Per-trunk service request |
| trkWrData | input | 64 | Per-trunk byte toward memory, trunk t in bits [8t+7:8t] |
| trkAck | output | 8 | Per-trunk one-cycle service acknowledge |
| trkRdData | output | 8 | Byte toward the acknowledged device |
| memReq | output | 1 | Memory byte request |
| memAddr | output | 24 | Memory byte address |
| memWrite | output | 1 | Memory direction, 1 = write |
| memWData | output | 8 | Byte to memory |
| memRdData | input | 8 | Byte from memory, valid with memReady |
| memReady | input | 1 | Memory completes the request |
| irq | output | 1 | Termination interrupt |
| irqAck | input | 1 | Software acknowledge, pops one termination |
| regAddr | output | 32 | Head termination: final address |
| regCmd | output | 32 | Head termination: device, trunk, direction, burst flag |
| regCount | output | 32 | Head termination: original byte count |
| regStatus | output | 32 | Pending flag and queue occupancy |

## Verification
The embedded properties take three things for granted. A device keeps its trkWrData byte steady while its request is raised. memReady is only meaningful while memReq is high. irqAck is a single-cycle pulse. The bench's device models hold fixed bytes on every trunk, and its memory model answers only a pending request, after a programmable number of wait cycles. The bench raises acknowledges one cycle at a time and only after it has seen irq. It drives every start command for exactly one cycle, so a command never overlaps the response to the previous one.

// File: rtl/mux_chan_pkg.sv
package mux_chan_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic startTs;   // open a time-shared operation
    logic startBr;   // open a burst operation
    logic grant;     // load the granted operation into the working registers
    logic byteDone;  // memory finished the current byte
    logic pop;       // software acknowledged the head termination
  } chanStrobe_t;

  localparam int CMD_TRK_LSB = 8;
  localparam int CMD_WR_BIT  = 11;
  localparam int CMD_BR_BIT  = 12;
endpackage

// File: rtl/mux_chan_ctrl.sv
module mux_chan_ctrl
  import mux_chan_pkg::*;
#(
  parameter int NUM_TRUNK = 8,
  localparam int TRK_W = $clog2(NUM_TRUNK)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startValid,
  input  logic                 startBurst,
  input  logic                 startBad,
  input  logic [NUM_TRUNK-1:0] trkReq,
  input  logic [NUM_TRUNK-1:0] trunkBusy,
  input  logic                 burstOn,
  input  logic [TRK_W-1:0]     burstTrunk,
  input  logic                 queueFull,
  input  logic                 queueEmpty,
  input  logic [TRK_W-1:0]     curTrunk,
  input  logic                 memReady,
  input  logic                 irqAck,
  output chanStrobe_t          st,
  output logic [TRK_W-1:0]     grantSel,
  output logic                 memReq,
  output logic [NUM_TRUNK-1:0] trkAck,
  output logic                 startOk,
  output logic                 startErr
);
  typedef enum logic {S_ARB, S_MEM} state_t;
  state_t state;
  logic [TRK_W-1:0] rrPtr;
  logic [NUM_TRUNK-1:0] svcMask, cand;
  logic found;

  always_comb begin
    svcMask = '0;
    if (burstOn) svcMask[burstTrunk] = 1'b1;
    else         svcMask = trunkBusy;
    // the trunk acknowledged this cycle has not yet seen its ack
    cand = trkReq & svcMask & ~trkAck;
    found = 1'b0;
    grantSel = '0;
    for (int i = 0; i < NUM_TRUNK; i++) begin
      if (!found && cand[TRK_W'(rrPtr + TRK_W'(i))]) begin
        found = 1'b1;
        grantSel = TRK_W'(rrPtr + TRK_W'(i));
      end
    end
  end

  assign memReq = (state == S_MEM);

  always_comb begin
    st.startTs  = startValid && !startBurst && !startBad;
    st.startBr  = startValid && startBurst && !startBad;
    st.grant    = (state == S_ARB) && found && !queueFull;
    st.byteDone = memReq && memReady;
    st.pop      = irqAck && !queueEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_ARB;
      rrPtr    <= '0;
      trkAck   <= '0;
      startOk  <= 1'b0;
      startErr <= 1'b0;
    end else begin
      startOk  <= startValid && !startBad;
      startErr <= startValid && startBad;
      trkAck   <= st.byteDone ? (NUM_TRUNK'(1) << curTrunk) : '0;
      if (st.grant) begin
        state <= S_MEM;
        rrPtr <= TRK_W'(grantSel + TRK_W'(1));
      end else if (st.byteDone) begin
        state <= S_ARB;
      end
    end
  end

  // R4: at most one trunk acknowledged per cycle
  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trkAck));
  // R8: during a burst only the burst trunk can be granted
  p_burst_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.grant && burstOn) |-> (grantSel == burstTrunk));
  // R3: a burst opens only on an otherwise idle channel
  p_burst_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.startBr |-> (trunkBusy == '0));
endmodule

// File: rtl/mux_chan_dp.sv
module mux_chan_dp
  import mux_chan_pkg::*;
#(
  parameter int NUM_TRUNK = 8,
  parameter int DEV_W     = 8,
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int QDEPTH    = 4,
  localparam int TRK_W    = $clog2(NUM_TRUNK),
  localparam int NUM_DEV  = 1 << DEV_W,
  localparam int QW       = $clog2(QDEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  chanStrobe_t            st,
  input  logic [TRK_W-1:0]       grantSel,
  input  logic [DEV_W-1:0]       startDev,
  input  logic [TRK_W-1:0]       startTrunk,
  input  logic [ADDR_W-1:0]      startAddr,
  input  logic [CNT_W-1:0]       startCount,
  input  logic                   startWrite,
  input  logic                   startBurst,
  output logic                   startBad,
  output logic [NUM_TRUNK-1:0]   trunkBusy,
  output logic                   burstOn,
  output logic [TRK_W-1:0]       burstTrunk,
  output logic                   queueFull,
  output logic                   queueEmpty,
  output logic [TRK_W-1:0]       curTrunk,
  input  logic [NUM_TRUNK*8-1:0] trkWrData,
  input  logic [7:0]             memRdData,
  output logic [7:0]             trkRdData,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWrite,
  output logic [7:0]             memWData,
  output logic                   irq,
  output logic [31:0]            regAddr,
  output logic [31:0]            regCmd,
  output logic [31:0]            regCount,
  output logic [31:0]            regStatus
);
  // per-device subchannel table (time-shared operations only)
  logic [ADDR_W-1:0] tblAddr [NUM_DEV];
  logic [CNT_W-1:0]  tblCnt  [NUM_DEV];
  // per-trunk operation bookkeeping
  logic [DEV_W-1:0]  trunkDev [NUM_TRUNK];
  logic              trunkWr  [NUM_TRUNK];
  logic [CNT_W-1:0]  trunkLen [NUM_TRUNK];
  // channel-level burst registers
  logic [DEV_W-1:0]  burstDev;
  logic              burstWr;
  logic [CNT_W-1:0]  burstLen, burstCnt;
  logic [ADDR_W-1:0] burstAddr;
  // working registers of the byte in service
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  curCnt, curLen;
  logic [DEV_W-1:0]  curDev;
  logic              curWrite, curBurst;
  // termination queue
  logic [ADDR_W-1:0] qAddr [QDEPTH];
  logic [DEV_W-1:0]  qDev  [QDEPTH];
  logic [TRK_W-1:0]  qTrk  [QDEPTH];
  logic              qWr   [QDEPTH];
  logic              qBr   [QDEPTH];
  logic [CNT_W-1:0]  qLen  [QDEPTH];
  logic [QW-1:0]     wrPtr, rdPtr;
  logic [QW:0]       qCount;

  logic devClash, lastByte, tblWe;
  logic [ADDR_W-1:0] nextAddr;
  logic [CNT_W-1:0]  nextCnt;

  always_comb begin
    devClash = 1'b0;
    for (int t = 0; t < NUM_TRUNK; t++)
      if (trunkBusy[t] && trunkDev[t] == startDev) devClash = 1'b1;
    startBad = (startCount == '0) || burstOn ||
               (startBurst ? (trunkBusy != '0) : (trunkBusy[startTrunk] || devClash));
  end

  assign nextAddr   = curAddr + ADDR_W'(1);
  assign nextCnt    = curCnt - CNT_W'(1);
  assign lastByte   = st.byteDone && (curCnt == CNT_W'(1));
  assign tblWe      = st.byteDone && !curBurst;
  assign queueFull  = (qCount == (QW+1)'(QDEPTH));
  assign queueEmpty = (qCount == '0);
  assign irq        = !queueEmpty;

  assign memAddr  = curAddr;
  assign memWrite = curWrite;
  assign memWData = trkWrData[curTrunk*8 +: 8];

  always_ff @(posedge clk) begin
    if (st.startTs) begin
      tblAddr[startDev] <= startAddr;
      tblCnt[startDev]  <= startCount;
      trunkDev[startTrunk] <= startDev;
      trunkWr[startTrunk]  <= startWrite;
      trunkLen[startTrunk] <= startCount;
    end
    if (tblWe) begin
      tblAddr[curDev] <= nextAddr;
      tblCnt[curDev]  <= nextCnt;
    end
    if (lastByte) begin
      qAddr[wrPtr] <= nextAddr;
      qDev[wrPtr]  <= curDev;
      qTrk[wrPtr]  <= curTrunk;
      qWr[wrPtr]   <= curWrite;
      qBr[wrPtr]   <= curBurst;
      qLen[wrPtr]  <= curLen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trunkBusy <= '0;
      burstOn <= 1'b0; burstTrunk <= '0; burstDev <= '0; burstWr <= 1'b0;
      burstLen <= '0; burstCnt <= '0; burstAddr <= '0;
      curTrunk <= '0; curAddr <= '0; curCnt <= '0; curLen <= '0;
      curDev <= '0; curWrite <= 1'b0; curBurst <= 1'b0;
      trkRdData <= '0;
      wrPtr <= '0; rdPtr <= '0; qCount <= '0;
    end else begin
      if (st.startTs) trunkBusy[startTrunk] <= 1'b1;
      if (st.startBr) begin
        burstOn <= 1'b1; burstTrunk <= startTrunk; burstDev <= startDev;
        burstWr <= startWrite; burstLen <= startCount;
        burstCnt <= startCount; burstAddr <= startAddr;
      end
      if (st.grant) begin
        curTrunk <= grantSel;
        curBurst <= burstOn;
        if (burstOn) begin
          curAddr <= burstAddr; curCnt <= burstCnt; curDev <= burstDev;
          curWrite <= burstWr; curLen <= burstLen;
        end else begin
          curAddr  <= tblAddr[trunkDev[grantSel]];
          curCnt   <= tblCnt[trunkDev[grantSel]];
          curDev   <= trunkDev[grantSel];
          curWrite <= trunkWr[grantSel];
          curLen   <= trunkLen[grantSel];
        end
      end
      if (st.byteDone) begin
        curAddr   <= nextAddr;
        curCnt    <= nextCnt;
        trkRdData <= memRdData;
        if (curBurst) begin
          burstAddr <= nextAddr;
          burstCnt  <= nextCnt;
        end
      end
      if (lastByte) begin
        if (curBurst) burstOn <= 1'b0;
        else          trunkBusy[curTrunk] <= 1'b0;
        wrPtr <= QW'(wrPtr + QW'(1));
      end
      if (st.pop) rdPtr <= QW'(rdPtr + QW'(1));
      qCount <= qCount + (QW+1)'(lastByte) - (QW+1)'(st.pop);
    end
  end

  always_comb begin
    regAddr  = 32'(qAddr[rdPtr]);
    regCount = 32'(qLen[rdPtr]);
    regCmd   = '0;
    regCmd[DEV_W-1:0] = qDev[rdPtr];
    regCmd[CMD_TRK_LSB +: TRK_W] = qTrk[rdPtr];
    regCmd[CMD_WR_BIT] = qWr[rdPtr];
    regCmd[CMD_BR_BIT] = qBr[rdPtr];
    regStatus = '0;
    regStatus[0] = irq;
    regStatus[8 +: QW+1] = qCount;
  end

  // R8: the subchannel table is never written while a burst owns the channel
  p_no_table_burst_r8: assert property (@(posedge clk) disable iff (!rstN)
    tblWe |-> !burstOn);
  // R12: a termination never lands in a full queue
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    lastByte |-> !queueFull);
  // R9: the interrupt holds until acknowledged
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !st.pop) |=> irq);
endmodule

// File: rtl/mux_io_channel.sv
module mux_io_channel
  import mux_chan_pkg::*;
#(
  parameter int NUM_TRUNK = 8,
  parameter int DEV_W     = 8,
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int QDEPTH    = 4,
  localparam int TRK_W    = $clog2(NUM_TRUNK)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startValid,
  input  logic [DEV_W-1:0]       startDev,
  input  logic [TRK_W-1:0]       startTrunk,
  input  logic [ADDR_W-1:0]      startAddr,
  input  logic [CNT_W-1:0]       startCount,
  input  logic                   startWrite,
  input  logic                   startBurst,
  output logic                   startOk,
  output logic                   startErr,
  input  logic [NUM_TRUNK-1:0]   trkReq,
  input  logic [NUM_TRUNK*8-1:0] trkWrData,
  output logic [NUM_TRUNK-1:0]   trkAck,
  output logic [7:0]             trkRdData,
  output logic                   memReq,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWrite,
  output logic [7:0]             memWData,
  input  logic [7:0]             memRdData,
  input  logic                   memReady,
  output logic                   irq,
  input  logic                   irqAck,
  output logic [31:0]            regAddr,
  output logic [31:0]            regCmd,
  output logic [31:0]            regCount,
  output logic [31:0]            regStatus
);
  chanStrobe_t st;
  logic [TRK_W-1:0] grantSel, burstTrunk, curTrunk;
  logic [NUM_TRUNK-1:0] trunkBusy;
  logic startBad, burstOn, queueFull, queueEmpty;

  mux_chan_ctrl #(.NUM_TRUNK(NUM_TRUNK)) u_ctrl (
    .clk, .rstN, .startValid, .startBurst, .startBad, .trkReq, .trunkBusy,
    .burstOn, .burstTrunk, .queueFull, .queueEmpty, .curTrunk, .memReady,
    .irqAck, .st, .grantSel, .memReq, .trkAck, .startOk, .startErr);

  mux_chan_dp #(.NUM_TRUNK(NUM_TRUNK), .DEV_W(DEV_W), .ADDR_W(ADDR_W),
                .CNT_W(CNT_W), .QDEPTH(QDEPTH)) u_dp (
    .clk, .rstN, .st, .grantSel, .startDev, .startTrunk, .startAddr,
    .startCount, .startWrite, .startBurst, .startBad, .trunkBusy, .burstOn,
    .burstTrunk, .queueFull, .queueEmpty, .curTrunk, .trkWrData, .memRdData,
    .trkRdData, .memAddr, .memWrite, .memWData, .irq, .regAddr, .regCmd,
    .regCount, .regStatus);

  // R4: a pending memory request keeps its address and direction
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWrite)));
endmodule

// File: tb/mux_io_channel_tb.sv
module mux_io_channel_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [7:0] startDev = '0;
  logic [2:0] startTrunk = '0;
  logic [23:0] startAddr = '0;
  logic [15:0] startCount = '0;
  logic startWrite = 1'b0, startBurst = 1'b0;
  logic startOk, startErr;
  logic [7:0] trkReq = '0;
  logic [63:0] trkWrData;
  logic [7:0] trkAck, trkRdData;
  logic memReq, memWrite;
  logic [23:0] memAddr;
  logic [7:0] memWData;
  logic [7:0] memRdData = '0;
  logic memReady = 1'b0;
  logic irq;
  logic irqAck = 1'b0;
  logic [31:0] regAddr, regCmd, regCount, regStatus;

  int checks = 0, errors = 0;
  int ackTrk [0:511];
  int ackAddr [0:511];
  int ackN = 0;
  int stall = 0, waitCnt = 0;
  logic [23:0] lastDoneAddr = '0;
  logic lastDoneWr = 1'b0;
  logic [7:0] lastDoneWData = '0;
  logic holdPend = 1'b0;
  logic [23:0] holdAddr = '0;

  always #2 clk = ~clk;

  for (genvar t = 0; t < 8; t++) begin : g_dev
    assign trkWrData[t*8 +: 8] = 8'hA0 + 8'(t);
  end

  mux_io_channel u_dut (.*);

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model and acknowledge monitor
  always @(negedge clk) begin
    if (trkAck != '0) begin
      int idx = 0;
      for (int t = 0; t < 8; t++) if (trkAck[t]) idx = t;
      ackTrk[ackN] = idx;
      ackAddr[ackN] = int'(lastDoneAddr);
      ackN++;
      if (!lastDoneWr)
        chk(trkRdData == (lastDoneAddr[7:0] ^ 8'h5A), "R4 read byte", int'(trkRdData),
            int'(lastDoneAddr[7:0] ^ 8'h5A));
      else
        chk(lastDoneWData == 8'hA0 + 8'(idx), "R4 write byte", int'(lastDoneWData),
            int'(8'hA0 + 8'(idx)));
    end
    if (memReq && holdPend)
      chk(memAddr == holdAddr, "R4 hold addr", int'(memAddr), int'(holdAddr));
    if (memReq) begin
      if (waitCnt >= stall) begin
        memReady = 1'b1;
        lastDoneAddr = memAddr;
        lastDoneWr = memWrite;
        lastDoneWData = memWData;
        memRdData = memAddr[7:0] ^ 8'h5A;
      end else memReady = 1'b0;
      waitCnt++;
    end else begin
      memReady = 1'b0;
      waitCnt = 0;
    end
    holdPend = memReq && !memReady;
    holdAddr = memAddr;
  end

  task automatic doStart(input int dev, input int trk, input int addr, input int cnt,
                         input bit wr, input bit br, output bit ok, output bit err);
    @(negedge clk);
    startValid = 1'b1; startDev = 8'(dev); startTrunk = 3'(trk);
    startAddr = 24'(addr); startCount = 16'(cnt); startWrite = wr; startBurst = br;
    @(negedge clk);
    startValid = 1'b0;
    ok = startOk; err = startErr;
  endtask

  task automatic waitIrq(output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      got = irq;
    end
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(memReq == 1'b0, "R1 memReq", int'(memReq), 0);
    chk(trkAck == '0, "R1 trkAck", int'(trkAck), 0);
    chk(startOk == 1'b0 && startErr == 1'b0, "R1 start resp", int'({startOk, startErr}), 0);
    chk(regStatus == '0, "R1 regStatus", int'(regStatus), 0);
  endtask

  task automatic testSingleRead();
    bit ok, err, got;
    int base;
    stall = 2;
    doStart(5, 2, 'h100, 4, 1'b0, 1'b0, ok, err);
    chk(ok && !err, "R2 accept", int'({ok, err}), 2);
    base = ackN;
    trkReq[2] = 1'b1;
    waitIrq(got);
    chk(got, "R9 irq rises", int'(got), 1);
    trkReq[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk(ackN - base == 4, "R5 byte count", ackN - base, 4);
    for (int k = 0; k < 4; k++) begin
      chk(ackTrk[base+k] == 2, "R5 trunk", ackTrk[base+k], 2);
      chk(ackAddr[base+k] == 'h100 + k, "R5 address", ackAddr[base+k], 'h100 + k);
    end
    chk(regAddr == 32'h104, "R9 regAddr", int'(regAddr), 'h104);
    chk(regCmd == 32'h205, "R9 regCmd", int'(regCmd), 'h205);
    chk(regCount == 32'd4, "R9 regCount", int'(regCount), 4);
    chk(regStatus == 32'h101, "R9 regStatus", int'(regStatus), 'h101);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R9 irq held", int'(irq), 1);
    pulseAck();
    chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
    stall = 0;
  endtask

  task automatic testRejects();
    bit ok, err, got;
    doStart(20, 5, 'h200, 2, 1'b1, 1'b0, ok, err);
    chk(ok && !err, "R2 accept", int'({ok, err}), 2);
    doStart(25, 6, 'h280, 0, 1'b0, 1'b0, ok, err);
    chk(!ok && err, "R2 zero count", int'({ok, err}), 1);
    doStart(21, 5, 'h2A0, 3, 1'b0, 1'b0, ok, err);
    chk(!ok && err, "R2 trunk busy", int'({ok, err}), 1);
    doStart(20, 7, 'h2C0, 3, 1'b0, 1'b0, ok, err);
    chk(!ok && err, "R2 device busy", int'({ok, err}), 1);
    doStart(22, 0, 'h2E0, 3, 1'b0, 1'b1, ok, err);
    chk(!ok && err, "R3 burst while busy", int'({ok, err}), 1);
    trkReq[5] = 1'b1;
    waitIrq(got);
    trkReq[5] = 1'b0;
    repeat (2) @(negedge clk);
    chk(regCmd == 32'hD14, "R9 regCmd write", int'(regCmd), 'hD14);
    pulseAck();
  endtask

  task automatic testInterleave();
    bit ok, err, got;
    int base, p, e;
    int rem [8];
    int devOf [8];
    int addrOf [8];
    int cntOf [8];
    int term [5];
    int nTerm = 0;
    devOf = '{44, 40, 0, 41, 43, 0, 42, 0};
    addrOf = '{'h340, 'h300, 0, 'h310, 'h330, 0, 'h320, 0};
    cntOf = '{2, 3, 0, 3, 1, 0, 3, 0};
    doStart(40, 1, 'h300, 3, 1'b0, 1'b0, ok, err);
    doStart(41, 3, 'h310, 3, 1'b1, 1'b0, ok, err);
    doStart(42, 6, 'h320, 3, 1'b0, 1'b0, ok, err);
    doStart(43, 4, 'h330, 1, 1'b0, 1'b0, ok, err);
    chk(ok, "R2 accept", int'(ok), 1);
    base = ackN;
    p = ackTrk[ackN-1];
    @(negedge clk);
    trkReq = 8'b0100_1010;
    for (int i = 0; i < 500 && ackN - base < 9; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ackN - base == 9, "R6 total services", ackN - base, 9);
    for (int t = 0; t < 8; t++) rem[t] = 0;
    rem[1] = 3; rem[3] = 3; rem[6] = 3;
    for (int k = 0; k < 9; k++) begin
      e = -1;
      for (int d = 1; d <= 8 && e < 0; d++) if (rem[(p + d) % 8] > 0) e = (p + d) % 8;
      chk(ackTrk[base+k] == e, "R6 rotation", ackTrk[base+k], e);
      if (e >= 0) begin
        rem[e]--;
        if (rem[e] == 0) begin term[nTerm] = e; nTerm++; end
      end
      p = ackTrk[base+k];
    end
    for (int k = 0; k < 9; k++)
      chk(ackTrk[base+k] != 4, "R7 idle trunk skipped", ackTrk[base+k], 4);
    chk(regStatus[15:8] == 8'd3, "R10 queue depth", int'(regStatus[15:8]), 3);
    trkReq[4] = 1'b1;
    for (int i = 0; i < 200 && ackN - base < 10; i++) @(negedge clk);
    term[nTerm] = 4; nTerm++;
    trkReq = '0;
    doStart(44, 0, 'h340, 2, 1'b0, 1'b0, ok, err);
    trkReq[0] = 1'b1;
    repeat (20) @(negedge clk);
    chk(ackN - base == 10, "R12 stalled when full", ackN - base, 10);
    term[nTerm] = 0; nTerm++;
    for (int k = 0; k < 5; k++) begin
      waitIrq(got);
      chk(got, "R10 irq pending", int'(got), 1);
      chk(regCmd[7:0] == 8'(devOf[term[k]]), "R10 order dev", int'(regCmd[7:0]), devOf[term[k]]);
      chk(regAddr == 32'(addrOf[term[k]] + cntOf[term[k]]), "R10 order addr", int'(regAddr),
          addrOf[term[k]] + cntOf[term[k]]);
      pulseAck();
    end
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 queue drained", int'(irq), 0);
    trkReq = '0;
  endtask

  task automatic testBurst();
    bit ok, err, got;
    int base;
    stall = 1;
    doStart(30, 7, 'h400, 5, 1'b1, 1'b1, ok, err);
    chk(ok && !err, "R3 burst accepted when idle", int'({ok, err}), 2);
    doStart(31, 2, 'h500, 1, 1'b0, 1'b0, ok, err);
    chk(!ok && err, "R8 start during burst", int'({ok, err}), 1);
    base = ackN;
    trkReq = 8'b1000_0100;
    waitIrq(got);
    trkReq = '0;
    repeat (3) @(negedge clk);
    chk(ackN - base == 5, "R8 burst services", ackN - base, 5);
    for (int k = 0; k < 5; k++) begin
      chk(ackTrk[base+k] == 7, "R8 burst trunk only", ackTrk[base+k], 7);
      chk(ackAddr[base+k] == 'h400 + k, "R5 burst address", ackAddr[base+k], 'h400 + k);
    end
    chk(regCmd == 32'h1F1E, "R11 regCmd", int'(regCmd), 'h1F1E);
    chk(regAddr == 32'h405, "R11 regAddr", int'(regAddr), 'h405);
    chk(regCount == 32'd5, "R11 regCount", int'(regCount), 5);
    pulseAck();
    doStart(31, 2, 'h500, 1, 1'b0, 1'b0, ok, err);
    chk(ok && !err, "R8 start after burst", int'({ok, err}), 2);
    trkReq[2] = 1'b1;
    waitIrq(got);
    trkReq = '0;
    pulseAck();
    stall = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingleRead();
    testRejects();
    testInterleave();
    testBurst();
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule